// File: doc/BRIEF.md
# Half-integer clock divider branch

This block is one branch of a clock tree. It selects one of several parent clocks, passes the result through an enable gate, and then divides it by a half-integer ratio of (2v+3)/2. Here v is an unsigned divide field of `DIV_W` bits, so the smallest ratio is 1.5, then 2.5, 3.5 and so on. The divider counts on both edges of the selected clock. Every output period therefore lasts exactly 2v+3 input half-periods, and the waveform is always the same shape.

Software sets the branch up through one 32-bit write port with two registers. The control register (address 0) holds the divide field and the parent-select field. The gate register (address 1) holds the enable bit. A parameter picks how writes behave. In masked mode, the upper half of the written word is a per-bit write enable for the lower half. In field mode, a write changes only the fields the branch owns. A combinational read port returns both registers. The mux is built only when there is more than one parent, and the gate only when `HAS_GATE` is set. The parent select is meant to be changed only while the gate is closed.

Top module: `hdiv_branch`

## Requirements
- R1: With the gate open and divide value v, every `clk_out` period equals 2v+3 half-periods of the selected parent clock. This holds for all v from 0 to 2^DIV_W-1.
- R2: Each `clk_out` high phase lasts v+2 parent half-periods, and the low phase lasts the remaining v+1.
- R3: `clk_out` is derived from `par_clk[s]`, where s is the select field at control bits [SEL_SHIFT +: SEL_W] (default bit 8). The select is changed only while the gate is closed.
- R4: In masked mode, a write to address 0 or 1 changes bit i (i < 16) only when bit i+16 of `wr_data` is 1. All other bits keep their values. The divide field sits at control bits [DIV_SHIFT +: DIV_W] (default [4:0]).
- R5: In field mode, a write to address 0 loads the divide field and, when writable, the select field. All other control bits are left unchanged. A write to address 1 loads only the gate bit.
- R6: With `MUX_RO` set, no write changes the select field. It keeps its reset value `SEL_RST`.
- R7: The enable is gate register bit `GATE_BIT` (default 3), active high. While it is 0, `clk_out` is low within three selected-clock edges. When it is set again, the divider starts over from count zero, so the first output pulse has full length.
- R8: A new divide value is loaded only at a frame boundary, where a frame is the pair of output periods that starts on a rising parent edge. Every output period seen during a change has either the old length or the new length.
- R9: After reset, the control register holds only `SEL_RST` in the select field, the gate register is 0, and `clk_out` is low.
- R10: A read of address 0 returns the control register in bits [15:0], and a read of address 1 returns the gate register. Bits [31:16] of the read data are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cfg | input | 1 | Register-port clock |
| rst_n | input | 1 | Asynchronous active-low reset for all state |
| wr_en | input | 1 | Write strobe, sampled on `clk_cfg` |
| wr_addr | input | 1 | Write target: 0 control, 1 gate |
| wr_data | input | 32 | Write word; upper half is the bit mask in masked mode |
| rd_addr | input | 1 | Read target: 0 control, 1 gate |
| rd_data | output | 32 | Read word, upper half zero |
| par_clk | input | NUM_PAR | Parent clocks |
| clk_out | output | 1 | Divided branch clock |

## Verification
The divider is run from a 10 ns parent at v = 0, 1, 2, 5 and the largest value 31. This covers the ratio-1.5 corner, both parities of v (the posedge and negedge event schedules differ with parity) and the widest count. A second run uses a 14 ns parent after a select change, which shows whether the mux routes the right clock and not merely the right divide count. A change of v while the divider is running separates loading at a frame boundary from loading mid-frame, because any other period length would show up. Register writes with full, partial and empty masks are compared against a second instance in field mode with a read-only select, which shows whether masking, field isolation and select locking are told apart.

// File: rtl/hdiv_pkg.sv
`timescale 1ns/1ps
package hdiv_pkg;

   typedef enum logic {
      HDIV_CTRL = 1'b0,
      HDIV_GATE = 1'b1
   } hdiv_addr_e;

   localparam int HDIV_REG_W = 16;

   function automatic logic [HDIV_REG_W-1:0] hdiv_merge(
      input logic [HDIV_REG_W-1:0] old_v,
      input logic [HDIV_REG_W-1:0] new_v,
      input logic [HDIV_REG_W-1:0] upd);
      return (old_v & ~upd) | (new_v & upd);
   endfunction

endpackage

// File: rtl/hdiv_regs.sv
`timescale 1ns/1ps
module hdiv_regs
   import hdiv_pkg::*;
#(
   parameter int NUM_PAR   = 2,
   parameter int SEL_W     = 1,
   parameter int SEL_SHIFT = 8,
   parameter int SEL_RST   = 0,
   parameter int DIV_W     = 5,
   parameter int DIV_SHIFT = 0,
   parameter bit MASK_MODE = 1'b1,
   parameter bit MUX_RO    = 1'b0,
   parameter bit HAS_GATE  = 1'b1,
   parameter int GATE_BIT  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_addr,
   input  logic [31:0]      wr_data,
   input  logic             rd_addr,
   output logic [31:0]      rd_data,
   output logic [SEL_W-1:0] sel,
   output logic [DIV_W-1:0] div,
   output logic             gate_on
);

   localparam logic [HDIV_REG_W-1:0] DIV_M    = HDIV_REG_W'(((1 << DIV_W) - 1) << DIV_SHIFT);
   localparam logic [HDIV_REG_W-1:0] SEL_M    = (NUM_PAR > 1) ?
                                               HDIV_REG_W'(((1 << SEL_W) - 1) << SEL_SHIFT) : '0;
   localparam logic [HDIV_REG_W-1:0] SEL_WR_M = MUX_RO ? '0 : SEL_M;
   localparam logic [HDIV_REG_W-1:0] SEL_LOCK = SEL_M & ~SEL_WR_M;
   localparam logic [HDIV_REG_W-1:0] GATE_M   = HAS_GATE ? HDIV_REG_W'(1 << GATE_BIT) : '0;
   localparam logic [HDIV_REG_W-1:0] CTRL_RST = (NUM_PAR > 1) ?
                                               HDIV_REG_W'(SEL_RST << SEL_SHIFT) : '0;

   logic [HDIV_REG_W-1:0] ctrl_q;
   logic [HDIV_REG_W-1:0] gate_q;
   logic [HDIV_REG_W-1:0] ctrl_upd;
   logic [HDIV_REG_W-1:0] gate_upd;

   generate
      if (MASK_MODE) begin : g_mask
         assign ctrl_upd = wr_data[31:16] & ~SEL_LOCK;
         assign gate_upd = wr_data[31:16];
      end else begin : g_field
         logic unused_hi;
         assign unused_hi = ^wr_data[31:16];
         assign ctrl_upd  = DIV_M | SEL_WR_M;
         assign gate_upd  = GATE_M;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_RST;
         gate_q <= '0;
      end else if (wr_en) begin
         if (wr_addr == HDIV_CTRL)
            ctrl_q <= hdiv_merge(ctrl_q, wr_data[15:0], ctrl_upd);
         else
            gate_q <= hdiv_merge(gate_q, wr_data[15:0], gate_upd);
      end
   end

   assign div     = ctrl_q[DIV_SHIFT +: DIV_W];
   assign rd_data = (rd_addr == HDIV_CTRL) ? {16'h0, ctrl_q} : {16'h0, gate_q};

   generate
      if (NUM_PAR > 1) begin : g_sel
         assign sel = ctrl_q[SEL_SHIFT +: SEL_W];
      end else begin : g_nosel
         assign sel = '0;
      end
      if (HAS_GATE) begin : g_gate
         assign gate_on = gate_q[GATE_BIT];
      end else begin : g_nogate
         assign gate_on = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/hdiv_clk_sel.sv
`timescale 1ns/1ps
module hdiv_clk_sel #(
   parameter int NUM_PAR = 2,
   parameter int SEL_W   = 1
) (
   input  logic [NUM_PAR-1:0] par_clk,
   input  logic [SEL_W-1:0]   sel,
   output logic               clk_sel
);

   generate
      if (NUM_PAR > 1) begin : g_mux
         assign clk_sel = (int'(sel) < NUM_PAR) ? par_clk[sel] : par_clk[0];
      end else begin : g_pass
         logic unused_sel;
         assign unused_sel = ^sel;
         assign clk_sel    = par_clk[0];
      end
   endgenerate

endmodule

// File: rtl/hdiv_core.sv
`timescale 1ns/1ps
module hdiv_core #(
   parameter int DIV_W = 5
) (
   input  logic             clk_in,
   input  logic             rst_n,
   input  logic             gate_on,
   input  logic [DIV_W-1:0] div_in,
   output logic             clk_out
);

   localparam int CW = DIV_W + 2;

   logic             en_s1, en_q;
   logic [DIV_W-1:0] div_s1, div_s2, act_q;
   logic [CW-1:0]    cnt_q, nxt, last, vv;
   logic [CW-1:0]    p_even, p_odd, n_odd, n_mid, n_even;
   logic             odd, pos_hit, neg_hit;
   logic             tp_q, tn_q;

   assign vv     = CW'(act_q);
   assign odd    = act_q[0];
   assign last   = {1'b0, act_q, 1'b0} + CW'(2);
   assign nxt    = (cnt_q >= last) ? '0 : cnt_q + CW'(1);

   assign p_even = (vv + CW'(2)) >> 1;
   assign p_odd  = (CW'(3) * vv + CW'(5)) >> 1;
   assign n_odd  = (vv + CW'(1)) >> 1;
   assign n_mid  = vv + CW'(1);
   assign n_even = (CW'(3) * vv + CW'(4)) >> 1;

   assign pos_hit = (nxt == '0) || (!odd && nxt == p_even) || (odd && nxt == p_odd);
   assign neg_hit = (odd && cnt_q == n_odd) || (cnt_q == n_mid) || (!odd && cnt_q == n_even);

   always_ff @(posedge clk_in or negedge rst_n) begin
      if (!rst_n) begin
         en_s1  <= 1'b0;
         en_q   <= 1'b0;
         div_s1 <= '0;
         div_s2 <= '0;
      end else begin
         en_s1  <= gate_on;
         en_q   <= en_s1;
         div_s1 <= div_in;
         div_s2 <= div_s1;
      end
   end

   always_ff @(posedge clk_in or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= '0;
      end else if (nxt == '0 && div_s1 == div_s2) begin
         act_q <= div_s2;
      end
   end

   always_ff @(posedge clk_in or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '1;
         tp_q  <= 1'b0;
      end else if (!en_q) begin
         cnt_q <= '1;
         tp_q  <= 1'b0;
      end else begin
         cnt_q <= nxt;
         if (pos_hit)
            tp_q <= ~tp_q;
      end
   end

   always_ff @(negedge clk_in or negedge rst_n) begin
      if (!rst_n)
         tn_q <= 1'b0;
      else if (!en_q)
         tn_q <= 1'b0;
      else if (neg_hit)
         tn_q <= ~tn_q;
   end

   assign clk_out = (tp_q ^ tn_q) & en_q;

endmodule

// File: rtl/hdiv_branch.sv
`timescale 1ns/1ps
module hdiv_branch
   import hdiv_pkg::*;
#(
   parameter int NUM_PAR   = 2,
   parameter int SEL_SHIFT = 8,
   parameter int SEL_RST   = 0,
   parameter int DIV_W     = 5,
   parameter int DIV_SHIFT = 0,
   parameter bit MASK_MODE = 1'b1,
   parameter bit MUX_RO    = 1'b0,
   parameter bit HAS_GATE  = 1'b1,
   parameter int GATE_BIT  = 3,
   localparam int SEL_W    = (NUM_PAR > 1) ? $clog2(NUM_PAR) : 1
) (
   input  logic               clk_cfg,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic               wr_addr,
   input  logic [31:0]        wr_data,
   input  logic               rd_addr,
   output logic [31:0]        rd_data,
   input  logic [NUM_PAR-1:0] par_clk,
   output logic               clk_out
);

   generate
      if (NUM_PAR < 1) begin : g_bad_par
         $error("hdiv_branch: NUM_PAR must be at least 1");
      end
      if (DIV_W < 1 || DIV_W > 12 || DIV_SHIFT + DIV_W > HDIV_REG_W) begin : g_bad_div
         $error("hdiv_branch: divide field does not fit the control register");
      end
      if (NUM_PAR > 1 && SEL_SHIFT + SEL_W > HDIV_REG_W) begin : g_bad_sel
         $error("hdiv_branch: select field does not fit the control register");
      end
      if (NUM_PAR > 1 && DIV_SHIFT < SEL_SHIFT + SEL_W && SEL_SHIFT < DIV_SHIFT + DIV_W) begin : g_overlap
         $error("hdiv_branch: select and divide fields overlap");
      end
      if (NUM_PAR > 1 && (SEL_RST < 0 || SEL_RST >= NUM_PAR)) begin : g_bad_rst
         $error("hdiv_branch: SEL_RST names no parent");
      end
      if (HAS_GATE && (GATE_BIT < 0 || GATE_BIT >= HDIV_REG_W)) begin : g_bad_gate
         $error("hdiv_branch: GATE_BIT outside the gate register");
      end
   endgenerate

   logic [SEL_W-1:0] sel_f;
   logic [DIV_W-1:0] div_f;
   logic             gate_on;
   logic             sel_clk;

   hdiv_regs #(
      .NUM_PAR  (NUM_PAR),
      .SEL_W    (SEL_W),
      .SEL_SHIFT(SEL_SHIFT),
      .SEL_RST  (SEL_RST),
      .DIV_W    (DIV_W),
      .DIV_SHIFT(DIV_SHIFT),
      .MASK_MODE(MASK_MODE),
      .MUX_RO   (MUX_RO),
      .HAS_GATE (HAS_GATE),
      .GATE_BIT (GATE_BIT)
   ) u_regs (
      .clk    (clk_cfg),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .rd_addr(rd_addr),
      .rd_data(rd_data),
      .sel    (sel_f),
      .div    (div_f),
      .gate_on(gate_on)
   );

   hdiv_clk_sel #(
      .NUM_PAR(NUM_PAR),
      .SEL_W  (SEL_W)
   ) u_sel (
      .par_clk(par_clk),
      .sel    (sel_f),
      .clk_sel(sel_clk)
   );

   hdiv_core #(
      .DIV_W(DIV_W)
   ) u_core (
      .clk_in (sel_clk),
      .rst_n  (rst_n),
      .gate_on(gate_on),
      .div_in (div_f),
      .clk_out(clk_out)
   );

endmodule

// File: rtl/hdiv_branch_chk.sv
`timescale 1ns/1ps
module hdiv_branch_chk #(
   parameter int SEL_W     = 1,
   parameter int DIV_W     = 5,
   parameter int DIV_SHIFT = 0,
   parameter bit MASK_MODE = 1'b1,
   parameter bit MUX_RO    = 1'b0
) (
   input logic             clk_cfg,
   input logic             rst_n,
   input logic             wr_en,
   input logic             wr_addr,
   input logic [31:0]      wr_data,
   input logic [SEL_W-1:0] sel_f,
   input logic [DIV_W-1:0] div_f,
   input logic             gate_on,
   input logic             sel_clk,
   input logic             clk_out
);

   logic unused_chk;
   assign unused_chk = ^wr_data;

   // R4
   div_mask_hold_chk: assert property (@(posedge clk_cfg) disable iff (!rst_n)
      (MASK_MODE && wr_en && wr_addr == 1'b0 && wr_data[16 + DIV_SHIFT +: DIV_W] == '0)
      |=> $stable(div_f));

   // R4
   div_mask_load_chk: assert property (@(posedge clk_cfg) disable iff (!rst_n)
      (MASK_MODE && wr_en && wr_addr == 1'b0 && (&wr_data[16 + DIV_SHIFT +: DIV_W]))
      |=> div_f == $past(wr_data[DIV_SHIFT +: DIV_W]));

   // R5
   div_field_load_chk: assert property (@(posedge clk_cfg) disable iff (!rst_n)
      (!MASK_MODE && wr_en && wr_addr == 1'b0)
      |=> div_f == $past(wr_data[DIV_SHIFT +: DIV_W]));

   // R6
   sel_ro_hold_chk: assert property (@(posedge clk_cfg) disable iff (!rst_n)
      (MUX_RO && wr_en) |=> $stable(sel_f));

   // R7
   gate_low_chk: assert property (@(posedge sel_clk) disable iff (!rst_n)
      (!gate_on && $past(!gate_on) && $past(!gate_on, 2)) |-> !clk_out);

endmodule

bind hdiv_branch hdiv_branch_chk #(
   .SEL_W    (SEL_W),
   .DIV_W    (DIV_W),
   .DIV_SHIFT(DIV_SHIFT),
   .MASK_MODE(MASK_MODE),
   .MUX_RO   (MUX_RO)
) u_chk (
   .clk_cfg(clk_cfg),
   .rst_n  (rst_n),
   .wr_en  (wr_en),
   .wr_addr(wr_addr),
   .wr_data(wr_data),
   .sel_f  (sel_f),
   .div_f  (div_f),
   .gate_on(gate_on),
   .sel_clk(sel_clk),
   .clk_out(clk_out)
);

// File: tb/hdiv_branch_bench.sv
`timescale 1ns/1ps
module hdiv_branch_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        p0 = 1'b0;
   logic        p1 = 1'b0;
   logic [1:0]  par_clk;
   logic        wr_en_a = 1'b0;
   logic        wr_en_b = 1'b0;
   logic        wr_addr = 1'b0;
   logic [31:0] wr_data = '0;
   logic        rd_addr = 1'b0;
   logic [31:0] rd_data_a, rd_data_b;
   logic        out_a, out_b;

   int n_chk  = 0;
   int n_fail = 0;
   int rise_cnt = 0;

   real   per_q[$];
   real   hi_q[$];
   string tag_q[$];
   real   t_rise = 0.0;
   real   t_fall = 0.0;
   bit    have_rise = 1'b0;

   always #2.5 clk = ~clk;
   always #5   p0 = ~p0;
   always #7   p1 = ~p1;
   assign par_clk = {p1, p0};

   hdiv_branch u_hdiv_branch (
      .clk_cfg(clk), .rst_n(rst_n), .wr_en(wr_en_a), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data_a),
      .par_clk(par_clk), .clk_out(out_a));

   hdiv_branch #(.MASK_MODE(1'b0), .MUX_RO(1'b1), .SEL_RST(1)) u_hdiv_branch_fld (
      .clk_cfg(clk), .rst_n(rst_n), .wr_en(wr_en_b), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data_b),
      .par_clk(par_clk), .clk_out(out_b));

   task automatic chk_i(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic chk_r(input string req, input real act, input real exp);
      n_chk++;
      if (act - exp > 0.01 || exp - act > 0.01) begin
         n_fail++;
         $display("FAIL %s actual %0.3f expected %0.3f", req, act, exp);
      end
   endtask

   // monitor: pops one expected item per output period
   always @(negedge out_a) t_fall = $realtime;
   always @(posedge out_a) begin
      real now;
      now = $realtime;
      rise_cnt++;
      if (have_rise && per_q.size() > 0) begin
         real ep, eh;
         string tg;
         ep = per_q.pop_front();
         eh = hi_q.pop_front();
         tg = tag_q.pop_front();
         chk_r({tg, " period"}, now - t_rise, ep);
         chk_r({tg, " high phase"}, t_fall - t_rise, eh);
      end
      t_rise = now;
      have_rise = 1'b1;
   end

   task automatic wr_a(input logic addr, input logic [31:0] d);
      @(negedge clk);
      wr_en_a = 1'b1; wr_addr = addr; wr_data = d;
      @(negedge clk);
      wr_en_a = 1'b0;
   endtask

   task automatic wr_b(input logic addr, input logic [31:0] d);
      @(negedge clk);
      wr_en_b = 1'b1; wr_addr = addr; wr_data = d;
      @(negedge clk);
      wr_en_b = 1'b0;
   endtask

   task automatic rd(input logic addr, output logic [31:0] da, output logic [31:0] db);
      @(negedge clk);
      rd_addr = addr;
      #1;
      da = rd_data_a;
      db = rd_data_b;
   endtask

   task automatic skip_rises(input int n);
      repeat (n) @(posedge out_a);
   endtask

   // driver: queue expected periods for the monitor
   task automatic expect_periods(input int v, input real half, input int n, input string tag);
      @(posedge out_a);
      #0.1;
      for (int i = 0; i < n; i++) begin
         per_q.push_back((2 * v + 3) * half);
         hi_q.push_back((v + 2) * half);
         tag_q.push_back(tag);
      end
      while (per_q.size() != 0) @(posedge clk);
   endtask

   task automatic set_div_a(input int v);
      wr_a(1'b0, 32'h001F_0000 | 32'(v));
      skip_rises(4);
   endtask

   task automatic report;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      #900000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual hung expected completion");
      report();
      $finish;
   end

   initial begin
      logic [31:0] da, db;
      int r0;
      real t0, t1, per;
      bit ok, last_ok;

      #40;
      @(negedge clk);
      rst_n = 1'b1;
      #20;

      // R9 / R10 reset state
      rd(1'b0, da, db);
      chk_i("R9 ctrl after reset", da, 32'h0000_0000);
      chk_i("R9 ctrl after reset, SEL_RST=1", db, 32'h0000_0100);
      rd(1'b1, da, db);
      chk_i("R9 gate after reset", da, 32'h0);
      chk_i("R9 clk_out low after reset", {31'h0, out_a}, 32'h0);

      // R4 masked writes
      wr_a(1'b0, 32'h001F_0002);
      rd(1'b0, da, db);
      chk_i("R4 masked divide load", da, 32'h0000_0002);
      wr_a(1'b0, 32'h0000_001F);
      rd(1'b0, da, db);
      chk_i("R4 empty mask ignored", da, 32'h0000_0002);
      wr_a(1'b0, 32'h1000_1FFF);
      rd(1'b0, da, db);
      chk_i("R4 single-bit mask, R10 upper half zero", da, 32'h0000_1002);
      wr_a(1'b1, 32'h0008_0008);
      rd(1'b1, da, db);
      chk_i("R10 gate readback", da, 32'h0000_0008);
      skip_rises(4);

      // R1 / R2 periods on the 10 ns parent
      expect_periods(2, 5.0, 3, "R1 R2 v=2");
      set_div_a(0);
      expect_periods(0, 5.0, 3, "R1 R2 v=0");
      set_div_a(5);
      expect_periods(5, 5.0, 3, "R1 R2 v=5");
      set_div_a(31);
      expect_periods(31, 5.0, 2, "R1 R2 v=31");
      set_div_a(1);
      expect_periods(1, 5.0, 3, "R1 R2 v=1");

      // R8 change while running: only 25 ns or 55 ns periods allowed
      wr_a(1'b0, 32'h001F_0004);
      @(posedge out_a);
      t0 = $realtime;
      ok = 1'b1;
      last_ok = 1'b0;
      for (int i = 0; i < 10; i++) begin
         @(posedge out_a);
         t1 = $realtime;
         per = t1 - t0;
         if (!((per > 24.99 && per < 25.01) || (per > 54.99 && per < 55.01))) begin
            ok = 1'b0;
            n_chk++;
            n_fail++;
            $display("FAIL R8 period during change actual %0.3f expected 25.000 or 55.000", per);
         end
         last_ok = (per > 54.99 && per < 55.01);
         t0 = t1;
      end
      if (ok) n_chk++;
      chk_i("R8 new value in force", {31'h0, last_ok}, 32'h1);

      // R7 gate closed holds output low
      wr_a(1'b1, 32'h0008_0000);
      #100;
      r0 = rise_cnt;
      #600;
      chk_i("R7 no rises while gated", 32'(rise_cnt - r0), 32'h0);
      chk_i("R7 clk_out low while gated", {31'h0, out_a}, 32'h0);

      // R3 select parent 1 while closed, then reopen
      wr_a(1'b0, 32'h0100_0100);
      rd(1'b0, da, db);
      chk_i("R3 select written", da, 32'h0000_1104);
      wr_a(1'b1, 32'h0008_0008);
      @(posedge out_a);
      t0 = $realtime;
      @(negedge out_a);
      t1 = $realtime;
      chk_r("R7 first pulse full after restart", t1 - t0, 42.0);
      expect_periods(4, 7.0, 3, "R3 R1 parent1 v=4");

      // R5 / R6 field-mode instance with read-only select
      wr_b(1'b0, 32'hFFFF_FFFF);
      rd(1'b0, da, db);
      chk_i("R5 R6 field write all ones", db, 32'h0000_011F);
      wr_b(1'b0, 32'h0000_0003);
      rd(1'b0, da, db);
      chk_i("R5 R6 field write keeps select", db, 32'h0000_0103);
      wr_b(1'b1, 32'h0000_FFFF);
      rd(1'b1, da, db);
      chk_i("R5 gate write only gate bit", db, 32'h0000_0008);
      wr_b(1'b1, 32'hFFFF_0000);
      rd(1'b1, da, db);
      chk_i("R5 gate bit cleared", db, 32'h0000_0000);

      report();
      $finish;
   end

endmodule